// File: doc/BRIEF.md
# Index Prefix Register Substitution Decoder

This block sits in the decode stage of an 8-bit accumulator processor. It watches the fetched byte stream and remembers whether an index prefix is pending. Byte 0xDD selects the first index register (IX) and byte 0xFD selects the second (IY). When the next opcode arrives, the block rewrites its register fields. References to the 16-bit HL pair move to the chosen index register. Operands that name H or L move to the high or low half of that index register.

If the opcode reads or writes memory through HL, the block takes one more byte from the stream as a signed displacement. It sign-extends that byte and adds it to the selected index register to form the address. For every decoded operation it also reports how many extra fetch units the prefix bytes and the displacement cost. Execution, the ALU and the bus side are not part of this block. The register-file values it needs for address forming come in as plain inputs.

Top module: `ixdec_top`

## Requirements
- R1: Synchronous active-high reset clears `op_valid` and drops any pending prefix, so an opcode that follows reset decodes unprefixed with `extra_cyc` = 0.
- R2: An unprefixed opcode yields one `op_valid` pulse one clock after the edge that accepts it. Kind codes: 1 = 8-bit load (01dddsss, except 0x76), 2 = ALU on A (10fffsss, with fff on `op_sub`), 3 = 8-bit increment (00rrr100), 4 = 8-bit decrement (00rrr101), 5 = INC HL (0x23), 6 = DEC HL (0x2B), 7 = PUSH HL (0xE5), 8 = POP HL (0xE1), 9 = HALT (0x76), 10 = any other byte. Register codes: B=0, C=1, D=2, E=3, H=4, L=5, memory=6, A=7, none=15.
- R3: After 0xDD, an operand that names H or L becomes IXH (8) or IXL (9). After 0xFD it becomes IYH (10) or IYL (11). Both operands of a register-to-register load are rewritten.
- R4: In the 16-bit forms (kinds 5 to 8), `pair_sel` reports HL=0, IX=1 or IY=2 according to the prefix. Any other kind reports 3.
- R5: A prefixed opcode with a memory operand (field 6) waits for one more byte and then emits `mem_mode` = 2 (indexed). That byte, sign-extended, appears on `disp`, and the non-memory operand keeps its plain H or L code.
- R6: For indexed mode, `mem_addr` = index register + sign-extended displacement, modulo 2^16. An unprefixed memory operand gives `mem_mode` = 1, `mem_addr` = `hl_val` and `disp` = 0. With no memory operand, `mem_mode` = 0.
- R7: When several prefix bytes arrive back to back, the last one decides the index register.
- R8: `extra_cyc` = the number of prefix bytes, plus 2 when a displacement is taken, saturating at 7.
- R9: The prefix is cleared once the prefixed operation is emitted, so the next opcode decodes unprefixed.
- R10: A prefix in front of an opcode with no H, L, HL or memory operand leaves that opcode's fields unchanged but still counts in `extra_cyc`.
- R11: Cycles with `byte_valid` low change no state: they do not lose a pending prefix and they produce no `op_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | `byte_in` carries a fetched byte this cycle |
| byte_in | input | 8 | Fetched instruction byte |
| hl_val | input | 16 | Current HL pair value |
| ix_val | input | 16 | Current IX value |
| iy_val | input | 16 | Current IY value |
| op_valid | output | 1 | One-cycle pulse: decoded operation fields are valid |
| op_kind | output | 4 | Operation kind code (R2) |
| op_sub | output | 3 | ALU function field |
| dst_sel | output | 4 | Destination register code |
| src_sel | output | 4 | Source register code |
| pair_sel | output | 2 | 16-bit pair code (R4) |
| mem_mode | output | 2 | 0 none, 1 via HL, 2 indexed |
| disp | output | 16 | Sign-extended displacement |
| mem_addr | output | 16 | Effective memory address |
| extra_cyc | output | 3 | Extra fetch units caused by prefixes and displacement |

## Verification
Each decoded result is registered. Its fields appear together with `op_valid` one clock after the edge that takes the final byte of the instruction: the opcode for register forms, or the displacement byte for indexed memory forms. Prefix bytes and the opcode byte of an indexed form raise no pulse. The bench drives every byte on a falling edge and reads all fields on the falling edge that follows the last accepting edge. It checks that `op_valid` is low again one cycle later, and it reads `op_valid` during idle gaps and during reset to confirm that nothing was emitted.

// File: rtl/ixdec_pkg.sv
package ixdec_pkg;

    localparam logic [7:0] PFX_X_BYTE = 8'hDD;
    localparam logic [7:0] PFX_Y_BYTE = 8'hFD;

    typedef enum logic [3:0] {
        RG_B    = 4'd0,
        RG_C    = 4'd1,
        RG_D    = 4'd2,
        RG_E    = 4'd3,
        RG_H    = 4'd4,
        RG_L    = 4'd5,
        RG_MEM  = 4'd6,
        RG_A    = 4'd7,
        RG_XH   = 4'd8,
        RG_XL   = 4'd9,
        RG_YH   = 4'd10,
        RG_YL   = 4'd11,
        RG_NONE = 4'd15
    } reg8_e;

    typedef enum logic [1:0] {
        PR_HL   = 2'd0,
        PR_IX   = 2'd1,
        PR_IY   = 2'd2,
        PR_NONE = 2'd3
    } pair_e;

    typedef enum logic [1:0] {
        AM_NONE = 2'd0,
        AM_HL   = 2'd1,
        AM_IDX  = 2'd2
    } amode_e;

    typedef enum logic [1:0] {
        IS_NONE = 2'd0,
        IS_X    = 2'd1,
        IS_Y    = 2'd2
    } isel_e;

    typedef enum logic [3:0] {
        OK_NONE  = 4'd0,
        OK_LD8   = 4'd1,
        OK_ALU   = 4'd2,
        OK_INC8  = 4'd3,
        OK_DEC8  = 4'd4,
        OK_INC16 = 4'd5,
        OK_DEC16 = 4'd6,
        OK_PUSH  = 4'd7,
        OK_POP   = 4'd8,
        OK_HALT  = 4'd9,
        OK_OTHER = 4'd10
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [2:0] sub;
        reg8_e      dst;
        reg8_e      src;
        pair_e      pair;
        amode_e     mode;
        logic       need_disp;
    } dec_t;

    function automatic logic is_prefix(logic [7:0] b);
        return (b == PFX_X_BYTE) || (b == PFX_Y_BYTE);
    endfunction

    // Map a 3-bit operand field to a register code, moving H/L onto index halves
    function automatic reg8_e map_reg(logic [2:0] f, logic used, isel_e sel, logic keep_plain);
        reg8_e r;
        if (!used) begin
            r = RG_NONE;
        end else begin
            r = reg8_e'({1'b0, f});
            if (!keep_plain && sel != IS_NONE) begin
                if (f == 3'd4) r = (sel == IS_X) ? RG_XH : RG_YH;
                if (f == 3'd5) r = (sel == IS_X) ? RG_XL : RG_YL;
            end
        end
        return r;
    endfunction

    function automatic logic is_x_half(reg8_e r);
        return (r == RG_XH) || (r == RG_XL);
    endfunction

    function automatic logic is_y_half(reg8_e r);
        return (r == RG_YH) || (r == RG_YL);
    endfunction

endpackage

// File: rtl/ixdec_remap.sv
module ixdec_remap
    import ixdec_pkg::*;
(
    input  logic [7:0] opc,
    input  isel_e      sel,
    output dec_t       dec
);

    op_kind_e   kind;
    logic [2:0] sub;
    logic [2:0] dst_f;
    logic [2:0] src_f;
    logic       dst_use;
    logic       src_use;
    logic       pair_use;
    logic       has_mem;

    // Base classification of the opcode byte
    always_comb begin
        kind     = OK_OTHER;
        sub      = 3'd0;
        dst_f    = 3'd0;
        src_f    = 3'd0;
        dst_use  = 1'b0;
        src_use  = 1'b0;
        pair_use = 1'b0;
        case (opc[7:6])
            2'b01: begin
                if (opc == 8'h76) begin
                    kind = OK_HALT;
                end else begin
                    kind    = OK_LD8;
                    dst_f   = opc[5:3];
                    src_f   = opc[2:0];
                    dst_use = 1'b1;
                    src_use = 1'b1;
                end
            end
            2'b10: begin
                kind    = OK_ALU;
                sub     = opc[5:3];
                dst_f   = 3'd7;
                src_f   = opc[2:0];
                dst_use = 1'b1;
                src_use = 1'b1;
            end
            2'b00: begin
                if (opc[2:1] == 2'b10) begin
                    kind    = opc[0] ? OK_DEC8 : OK_INC8;
                    dst_f   = opc[5:3];
                    src_f   = opc[5:3];
                    dst_use = 1'b1;
                    src_use = 1'b1;
                end else if (opc == 8'h23) begin
                    kind     = OK_INC16;
                    pair_use = 1'b1;
                end else if (opc == 8'h2B) begin
                    kind     = OK_DEC16;
                    pair_use = 1'b1;
                end
            end
            default: begin
                if (opc == 8'hE5) begin
                    kind     = OK_PUSH;
                    pair_use = 1'b1;
                end else if (opc == 8'hE1) begin
                    kind     = OK_POP;
                    pair_use = 1'b1;
                end
            end
        endcase
    end

    assign has_mem = (dst_use && dst_f == 3'd6) || (src_use && src_f == 3'd6);

    // Substitution: with a memory operand the other operand stays plain
    always_comb begin
        dec.kind = kind;
        dec.sub  = sub;
        dec.dst  = map_reg(dst_f, dst_use, sel, has_mem);
        dec.src  = map_reg(src_f, src_use, sel, has_mem);
        if (!pair_use)          dec.pair = PR_NONE;
        else if (sel == IS_X)   dec.pair = PR_IX;
        else if (sel == IS_Y)   dec.pair = PR_IY;
        else                    dec.pair = PR_HL;
        if (!has_mem)           dec.mode = AM_NONE;
        else if (sel != IS_NONE) dec.mode = AM_IDX;
        else                    dec.mode = AM_HL;
        dec.need_disp = has_mem && (sel != IS_NONE);
    end

endmodule

// File: rtl/ixdec_addr.sv
module ixdec_addr #(
    parameter int ADDR_W = 16
) (
    input  logic [7:0]        d_byte,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] d_ext,
    output logic [ADDR_W-1:0] addr
);

    localparam int EXT_W = ADDR_W - 8;

    assign d_ext = {{EXT_W{d_byte[7]}}, d_byte};
    assign addr  = base + d_ext;

endmodule

// File: rtl/ixdec_top.sv
module ixdec_top
    import ixdec_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int EXTRA_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               byte_valid,
    input  logic [7:0]         byte_in,
    input  logic [ADDR_W-1:0]  hl_val,
    input  logic [ADDR_W-1:0]  ix_val,
    input  logic [ADDR_W-1:0]  iy_val,
    output logic               op_valid,
    output logic [3:0]         op_kind,
    output logic [2:0]         op_sub,
    output logic [3:0]         dst_sel,
    output logic [3:0]         src_sel,
    output logic [1:0]         pair_sel,
    output logic [1:0]         mem_mode,
    output logic [ADDR_W-1:0]  disp,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [EXTRA_W-1:0] extra_cyc
);

    localparam int EXT_W = ADDR_W - 8;

    typedef enum logic {ST_OPC, ST_DISP} st_e;

    st_e                st_q;
    isel_e              sel_q;
    logic [EXTRA_W-1:0] npfx_q;
    dec_t               held_q;
    dec_t               dec_now;
    dec_t               out_q;
    logic [ADDR_W-1:0]  idx_base;
    logic [ADDR_W-1:0]  d_ext;
    logic [ADDR_W-1:0]  idx_addr;

    function automatic logic [EXTRA_W-1:0] sat_add(logic [EXTRA_W-1:0] a, logic [1:0] b);
        logic [EXTRA_W:0] s;
        s = {1'b0, a} + {{(EXTRA_W-1){1'b0}}, b};
        return s[EXTRA_W] ? {EXTRA_W{1'b1}} : s[EXTRA_W-1:0];
    endfunction

    ixdec_remap u_remap (
        .opc (byte_in),
        .sel (sel_q),
        .dec (dec_now)
    );

    assign idx_base = (sel_q == IS_X) ? ix_val : iy_val;

    ixdec_addr #(.ADDR_W(ADDR_W)) u_addr (
        .d_byte (byte_in),
        .base   (idx_base),
        .d_ext  (d_ext),
        .addr   (idx_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_OPC;
            sel_q     <= IS_NONE;
            npfx_q    <= '0;
            held_q    <= '{kind: OK_NONE, sub: 3'd0, dst: RG_NONE, src: RG_NONE,
                           pair: PR_NONE, mode: AM_NONE, need_disp: 1'b0};
            out_q     <= '{kind: OK_NONE, sub: 3'd0, dst: RG_NONE, src: RG_NONE,
                           pair: PR_NONE, mode: AM_NONE, need_disp: 1'b0};
            op_valid  <= 1'b0;
            disp      <= '0;
            mem_addr  <= '0;
            extra_cyc <= '0;
        end else begin
            op_valid <= 1'b0;
            if (byte_valid) begin
                case (st_q)
                    ST_OPC: begin
                        if (is_prefix(byte_in)) begin
                            sel_q  <= (byte_in == PFX_X_BYTE) ? IS_X : IS_Y;
                            npfx_q <= sat_add(npfx_q, 2'd1);
                        end else if (dec_now.need_disp) begin
                            held_q <= dec_now;
                            st_q   <= ST_DISP;
                        end else begin
                            out_q     <= dec_now;
                            op_valid  <= 1'b1;
                            disp      <= '0;
                            mem_addr  <= (dec_now.mode == AM_HL) ? hl_val : '0;
                            extra_cyc <= npfx_q;
                            sel_q     <= IS_NONE;
                            npfx_q    <= '0;
                        end
                    end
                    default: begin
                        out_q     <= held_q;
                        op_valid  <= 1'b1;
                        disp      <= d_ext;
                        mem_addr  <= idx_addr;
                        extra_cyc <= sat_add(npfx_q, 2'd2);
                        sel_q     <= IS_NONE;
                        npfx_q    <= '0;
                        st_q      <= ST_OPC;
                    end
                endcase
            end
        end
    end

    assign op_kind  = out_q.kind;
    assign op_sub   = out_q.sub;
    assign dst_sel  = out_q.dst;
    assign src_sel  = out_q.src;
    assign pair_sel = out_q.pair;
    assign mem_mode = out_q.mode;

    // R5: an indexed result only follows a displacement byte
    assert_idx_after_disp_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && out_q.mode == AM_IDX) |-> ($past(st_q) == ST_DISP));

    // R5: displacement upper bits replicate bit 7
    assert_disp_sext_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && out_q.mode == AM_IDX) |-> (disp[ADDR_W-1:8] == {EXT_W{disp[7]}}));

    // R5: the non-memory operand of an indexed form is never an index half
    assert_no_half_with_mem_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && out_q.mode == AM_IDX) |->
            !(is_x_half(out_q.dst) || is_y_half(out_q.dst) ||
              is_x_half(out_q.src) || is_y_half(out_q.src)));

    // R3: never both index registers in one operation
    assert_single_index_R3: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> !((is_x_half(out_q.dst) || is_x_half(out_q.src)) &&
                       (is_y_half(out_q.dst) || is_y_half(out_q.src))));

    // R8: an indexed access costs at least three extra units
    assert_idx_extra_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && out_q.mode == AM_IDX) |-> (extra_cyc >= EXTRA_W'(3)));

    // R8: an index half is never used for free
    assert_half_extra_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (is_x_half(out_q.dst) || is_y_half(out_q.src) ||
                      is_y_half(out_q.dst) || is_x_half(out_q.src)))
            |-> (extra_cyc != '0));

    // R9: prefix state is gone once an operation is emitted
    assert_prefix_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> (sel_q == IS_NONE && npfx_q == '0 && st_q == ST_OPC));

    // R2/R11: back-to-back pulses need a byte accepted in between
    assert_pulse_needs_byte_R11: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (!op_valid || $past(byte_valid)));

endmodule

// File: tb/tb_ixdec_top.sv
module tb_ixdec_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [15:0] hl_val = 16'h4000;
    logic [15:0] ix_val = 16'h8000;
    logic [15:0] iy_val = 16'h0010;
    logic        op_valid;
    logic [3:0]  op_kind;
    logic [2:0]  op_sub;
    logic [3:0]  dst_sel;
    logic [3:0]  src_sel;
    logic [1:0]  pair_sel;
    logic [1:0]  mem_mode;
    logic [15:0] disp;
    logic [15:0] mem_addr;
    logic [2:0]  extra_cyc;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    ixdec_top dut (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
        .hl_val(hl_val), .ix_val(ix_val), .iy_val(iy_val),
        .op_valid(op_valid), .op_kind(op_kind), .op_sub(op_sub),
        .dst_sel(dst_sel), .src_sel(src_sel), .pair_sel(pair_sel),
        .mem_mode(mem_mode), .disp(disp), .mem_addr(mem_addr),
        .extra_cyc(extra_cyc)
    );

    typedef struct packed {
        logic [31:0] bytes;
        logic [2:0]  n;
        logic [3:0]  kind;
        logic [3:0]  dst;
        logic [3:0]  src;
        logic [1:0]  pair;
        logic [1:0]  mode;
        logic [15:0] dsp;
        logic [15:0] addr;
        logic [2:0]  extra;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{32'h7800_0000, 3'd1, 4'd1, 4'd7, 4'd0, 2'd3, 2'd0, 16'h0000, 16'h0000, 3'd0, 4'd2},  // R2 LD A,B
        '{32'h8600_0000, 3'd1, 4'd2, 4'd7, 4'd6, 2'd3, 2'd1, 16'h0000, 16'h4000, 3'd0, 4'd6},  // R6 ADD A,(HL)
        '{32'hDD67_0000, 3'd2, 4'd1, 4'd8, 4'd7, 2'd3, 2'd0, 16'h0000, 16'h0000, 3'd1, 4'd3},  // R3 LD IXH,A
        '{32'hFD45_0000, 3'd2, 4'd1, 4'd0, 4'd11,2'd3, 2'd0, 16'h0000, 16'h0000, 3'd1, 4'd3},  // R3 LD B,IYL
        '{32'hDD65_0000, 3'd2, 4'd1, 4'd8, 4'd9, 2'd3, 2'd0, 16'h0000, 16'h0000, 3'd1, 4'd3},  // R3 LD IXH,IXL
        '{32'hFD23_0000, 3'd2, 4'd5, 4'd15,4'd15,2'd2, 2'd0, 16'h0000, 16'h0000, 3'd1, 4'd4},  // R4 INC IY
        '{32'hDDE5_0000, 3'd2, 4'd7, 4'd15,4'd15,2'd1, 2'd0, 16'h0000, 16'h0000, 3'd1, 4'd4},  // R4 PUSH IX
        '{32'h2B00_0000, 3'd1, 4'd6, 4'd15,4'd15,2'd0, 2'd0, 16'h0000, 16'h0000, 3'd0, 4'd4},  // R4 DEC HL
        '{32'hDD66_FE00, 3'd3, 4'd1, 4'd4, 4'd6, 2'd3, 2'd2, 16'hFFFE, 16'h7FFE, 3'd3, 4'd5},  // R5 LD H,(IX-2)
        '{32'hFD77_8000, 3'd3, 4'd1, 4'd6, 4'd7, 2'd3, 2'd2, 16'hFF80, 16'hFF90, 3'd3, 4'd6},  // R6 LD (IY-128),A wraps
        '{32'hDD34_7F00, 3'd3, 4'd3, 4'd6, 4'd6, 2'd3, 2'd2, 16'h007F, 16'h807F, 3'd3, 4'd6},  // R6 INC (IX+127)
        '{32'hDDFD_4400, 3'd3, 4'd1, 4'd0, 4'd10,2'd3, 2'd0, 16'h0000, 16'h0000, 3'd2, 4'd7},  // R7 FD wins
        '{32'hFDDD_7D00, 3'd3, 4'd1, 4'd7, 4'd9, 2'd3, 2'd0, 16'h0000, 16'h0000, 3'd2, 4'd7},  // R7 DD wins
        '{32'hDD00_0000, 3'd2, 4'd10,4'd15,4'd15,2'd3, 2'd0, 16'h0000, 16'h0000, 3'd1, 4'd10}, // R10 other
        '{32'hDD47_0000, 3'd2, 4'd1, 4'd0, 4'd7, 2'd3, 2'd0, 16'h0000, 16'h0000, 3'd1, 4'd10}, // R10 LD B,A
        '{32'h4400_0000, 3'd1, 4'd1, 4'd0, 4'd4, 2'd3, 2'd0, 16'h0000, 16'h0000, 3'd0, 4'd9},  // R9 plain after prefix
        '{32'hFD2D_0000, 3'd2, 4'd4, 4'd11,4'd11,2'd3, 2'd0, 16'h0000, 16'h0000, 3'd1, 4'd3},  // R3 DEC IYL
        '{32'hDDDD_96FF, 3'd4, 4'd2, 4'd7, 4'd6, 2'd3, 2'd2, 16'hFFFF, 16'h7FFF, 3'd4, 4'd8}   // R8 SUB (IX-1)
    };

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_in    = b;
        byte_valid = 1'b1;
        @(posedge clk);
    endtask

    task automatic finish_bytes();
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic expect_op(input int req, input logic [3:0] kind, input logic [3:0] dst,
                             input logic [3:0] src, input logic [1:0] pair, input logic [1:0] mode,
                             input logic [15:0] dsp, input logic [15:0] addr, input logic [2:0] extra);
        check(req, "op_valid", 32'(op_valid), 32'd1);
        check(req, "op_kind", 32'(op_kind), 32'(kind));
        check(req, "dst_sel", 32'(dst_sel), 32'(dst));
        check(req, "src_sel", 32'(src_sel), 32'(src));
        check(req, "pair_sel", 32'(pair_sel), 32'(pair));
        check(req, "mem_mode", 32'(mem_mode), 32'(mode));
        check(req, "disp", 32'(disp), 32'(dsp));
        check(req, "mem_addr", 32'(mem_addr), 32'(addr));
        check(req, "extra_cyc", 32'(extra_cyc), 32'(extra));
    endtask

    task automatic run_vec(input vec_t v);
        for (int i = 0; i < int'(v.n); i++) begin
            if (i > 0) check(int'(v.req), "no early pulse", 32'(op_valid), 32'd0);
            send_byte(v.bytes[31 - 8*i -: 8]);
        end
        finish_bytes();
        expect_op(int'(v.req), v.kind, v.dst, v.src, v.pair, v.mode, v.dsp, v.addr, v.extra);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1: outputs idle during reset
        repeat (3) @(negedge clk);
        check(1, "op_valid in reset", 32'(op_valid), 32'd0);
        rst = 1'b0;

        // R1: first opcode after reset decodes plain
        send_byte(8'h67);
        finish_bytes();
        expect_op(1, 4'd1, 4'd4, 4'd7, 2'd3, 2'd0, 16'h0, 16'h0, 3'd0);
        // R2: pulse lasts one cycle
        @(negedge clk);
        check(2, "pulse ends", 32'(op_valid), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R2: ALU function field (XOR A,E = 0xAB)
        send_byte(8'hAB);
        finish_bytes();
        check(2, "op_sub", 32'(op_sub), 32'd5);
        check(2, "alu kind", 32'(op_kind), 32'd2);

        // R1: reset drops a pending prefix
        send_byte(8'hDD);
        finish_bytes();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        send_byte(8'h67);
        finish_bytes();
        expect_op(1, 4'd1, 4'd4, 4'd7, 2'd3, 2'd0, 16'h0, 16'h0, 3'd0);

        // R11: idle cycles keep the prefix and emit nothing
        send_byte(8'hDD);
        @(negedge clk);
        byte_valid = 1'b0;
        byte_in    = 8'hFD;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(11, "no pulse while idle", 32'(op_valid), 32'd0);
        end
        send_byte(8'h67);
        finish_bytes();
        expect_op(11, 4'd1, 4'd8, 4'd7, 2'd3, 2'd0, 16'h0, 16'h0, 3'd1);

        // R8: count saturates at 7
        for (int k = 0; k < 8; k++) send_byte(8'hDD);
        send_byte(8'h00);
        finish_bytes();
        check(8, "extra saturates", 32'(extra_cyc), 32'd7);
        check(8, "other kind", 32'(op_kind), 32'd10);

        // R9: next opcode is plain again
        send_byte(8'h6C);
        finish_bytes();
        expect_op(9, 4'd1, 4'd5, 4'd4, 2'd3, 2'd0, 16'h0, 16'h0, 3'd0);

        // R6: new index value is used
        ix_val = 16'hFFF0;
        send_byte(8'hDD);
        send_byte(8'h7E);
        send_byte(8'h20);
        finish_bytes();
        expect_op(6, 4'd1, 4'd7, 4'd6, 2'd3, 2'd2, 16'h0020, 16'h0010, 3'd3);

        summary();
    end

endmodule